// File: doc/BRIEF.md
# Per-Group DMA Access Protection Checker

This block decides, for each DMA access, whether the issuing master may touch the target address. A request carries a master index and a 32-bit address. The master index selects a master configuration word, and the low bits of that word name a protection group. The group's control word selects one of three outcomes:
- deny everything;
- allow everything;
- consult a permission vector in memory, which holds one bit per page.

In the checked case the block fetches a single 32-bit vector word over a simple read port with a request pulse and a valid return. It then answers with grant or deny. A deny also raises a one-cycle access-denied event that carries the failing address.

The master and group tables come in as flat configuration buses. A global enable input turns checking off: while it is low, every access is granted. The page size is 4 KiB scaled by a power of two taken from a page-size input. A build parameter can fix the page size at 4 KiB instead. Only one lookup is in flight at a time.

Top module: `apv_guard`

## Requirements
- R1: After reset, req_ready_o is 1 and rsp_valid_o, rsp_grant_o, denied_o and mem_req_o are 0.
- R2: When en_i is 0 at acceptance, the access is granted with no memory read, and rsp_valid_o rises in the cycle after acceptance.
- R3: A group word with bit 0 clear (inactive) denies the access with no memory read, whatever bit 1 holds.
- R4: A group word with bits 0 and 1 both set grants the access with no memory read.
- R5: A group word with bit 0 set and bit 1 clear issues exactly one vector read. The read address is {group[31:4], 4'b0000} + 4 * (page >> 5).
- R6: The page index is addr >> (12 + pgsz_i), that is, a page of 4 KiB << pgsz_i.
- R7: The vector bit used is bit 31 - (page mod 32), so page offset 0 maps to bit 31. A bit value of 1 denies and 0 grants.
- R8: The group of a master is taken from bits 3:0 of its master word, and bits 31:4 are ignored.
- R9: Only one lookup is outstanding. req_ready_o is 0 from acceptance through the response cycle and returns to 1 in the cycle after. mem_req_o is a single-cycle pulse per lookup.
- R10: A denied response pulses denied_o for one cycle, together with rsp_valid_o, with denied_addr_o equal to the request address. A granted response leaves denied_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Checking enable; 0 grants everything |
| pgsz_i | input | PG_W | Page-size exponent above 4 KiB |
| mst_cfg_i | input | NUM_MASTERS*32 | Master configuration words, master 0 in the low 32 bits |
| grp_cfg_i | input | NUM_GROUPS*32 | Group control words, group 0 in the low 32 bits |
| req_valid_i | input | 1 | Access request valid |
| req_ready_o | output | 1 | Checker idle, request accepted when valid |
| req_master_i | input | MST_W | Master index of the access |
| req_addr_i | input | 32 | Target address of the access |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_grant_o | output | 1 | Access granted (qualified by rsp_valid_o) |
| denied_o | output | 1 | Access-denied event pulse |
| denied_addr_o | output | 32 | Failing address during denied_o |
| mem_req_o | output | 1 | Vector word read request pulse |
| mem_addr_o | output | 32 | Vector word byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Vector word read data |

## Verification
The assertions check the handshake and mode outcomes on every cycle:
- a read request never lasts more than one cycle;
- no request is accepted while a response is showing;
- the deny event never lasts two cycles;
- bypass, disabled and passthrough accesses go straight to their response without a fetch;
- checked accesses always start a fetch.

Only the bench scenarios can show the arithmetic. This covers the vector word address and the MSB-first bit choice for several page sizes, the mapping from master word to group that ignores the upper bits, and the failing address reported with a deny.

// File: rtl/apv_pkg.sv
package apv_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned BASE_LSB   = 4;
  localparam int unsigned PAGE_SHIFT = 12;

  typedef enum logic [1:0] {GM_OFF, GM_PASS, GM_CHECK} grp_mode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT, ST_RESP} ctl_st_e;

  function automatic grp_mode_e decode_mode(input logic act, input logic pass);
    if (!act)     return GM_OFF;
    else if (pass) return GM_PASS;
    else          return GM_CHECK;
  endfunction
endpackage

// File: rtl/apv_group_sel.sv
module apv_group_sel
  import apv_pkg::*;
#(
  parameter int NUM_MASTERS = 8,
  parameter int NUM_GROUPS  = 16,
  localparam int MST_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic [MST_W-1:0]              master_i,
  input  logic [NUM_MASTERS*WORD_W-1:0] mst_cfg_i,
  input  logic [NUM_GROUPS*WORD_W-1:0]  grp_cfg_i,
  output grp_mode_e                     mode_o,
  output logic [WORD_W-1:0]             base_o
);
  logic [WORD_W-1:0] mst_tbl [NUM_MASTERS];
  logic [WORD_W-1:0] grp_tbl [NUM_GROUPS];

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mst
    assign mst_tbl[m] = mst_cfg_i[m*WORD_W +: WORD_W];
  end
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_tbl[g] = grp_cfg_i[g*WORD_W +: WORD_W];
  end

  logic [WORD_W-1:0] mst_word, grp_word;
  logic [GRP_W-1:0]  grp_idx;

  assign mst_word = mst_tbl[master_i];
  assign grp_idx  = mst_word[GRP_W-1:0];   // group field sits in the low nibble
  assign grp_word = grp_tbl[grp_idx];

  assign mode_o = decode_mode(grp_word[0], grp_word[1]);
  assign base_o = {grp_word[WORD_W-1:BASE_LSB], {BASE_LSB{1'b0}}};

  logic unused_cfg;
  assign unused_cfg = ^{mst_word[WORD_W-1:GRP_W], grp_word[BASE_LSB-1:2]};
endmodule

// File: rtl/apv_index.sv
module apv_index
  import apv_pkg::*;
#(
  parameter int PG_W     = 3,
  parameter bit CFG_PGSZ = 1'b1
) (
  input  logic [WORD_W-1:0] addr_i,
  input  logic [WORD_W-1:0] base_i,
  input  logic [PG_W-1:0]   pgsz_i,
  output logic [WORD_W-1:0] word_addr_o,
  output logic [4:0]        bit_o
);
  logic [5:0]        shamt;
  logic [WORD_W-1:0] page;

  if (CFG_PGSZ) begin : g_cfg
    assign shamt = 6'(PAGE_SHIFT) + 6'(pgsz_i);
  end else begin : g_fix
    assign shamt = 6'(PAGE_SHIFT);
    logic unused_pg;
    assign unused_pg = ^pgsz_i;
  end

  assign page        = addr_i >> shamt;
  // one vector word covers 32 pages; word index scaled to bytes
  assign word_addr_o = base_i + {page[WORD_W-1:5], 2'b00};
  assign bit_o       = 5'd31 - page[4:0];  // MSB-first within the word
endmodule

// File: rtl/apv_ctrl.sv
module apv_ctrl
  import apv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [WORD_W-1:0] addr_i,
  input  grp_mode_e         mode_i,
  input  logic [WORD_W-1:0] word_addr_i,
  input  logic [4:0]        bit_i,
  output logic              mem_req_o,
  output logic [WORD_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_grant_o,
  output logic              denied_o,
  output logic [WORD_W-1:0] denied_addr_o
);
  ctl_st_e           st_q;
  logic [WORD_W-1:0] addr_q, waddr_q;
  logic [4:0]        bit_q;
  logic              grant_q;
  logic              accept;

  assign accept = req_valid_i && (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      waddr_q <= '0;
      bit_q   <= '0;
      grant_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= addr_i;
          waddr_q <= word_addr_i;
          bit_q   <= bit_i;
          if (!en_i || mode_i == GM_PASS) begin
            grant_q <= 1'b1;
            st_q    <= ST_RESP;
          end else if (mode_i == GM_OFF) begin
            grant_q <= 1'b0;
            st_q    <= ST_RESP;
          end else begin
            st_q    <= ST_FETCH;
          end
        end
        ST_FETCH: st_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid_i) begin
          grant_q <= ~mem_rdata_i[bit_q];  // set bit means page blocked
          st_q    <= ST_RESP;
        end
        ST_RESP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (st_q == ST_IDLE);
  assign mem_req_o     = (st_q == ST_FETCH);
  assign mem_addr_o    = waddr_q;
  assign rsp_valid_o   = (st_q == ST_RESP);
  assign rsp_grant_o   = rsp_valid_o && grant_q;
  assign denied_o      = rsp_valid_o && !grant_q;
  assign denied_addr_o = denied_o ? addr_q : '0;

  AST_FETCH_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);                                              // R9
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);                                          // R9
  AST_DENY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    denied_o |=> !denied_o);                                                // R10
  AST_BYPASS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !en_i) |=> (rsp_valid_o && rsp_grant_o && !mem_req_o));     // R2
  AST_OFF_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && en_i && mode_i == GM_OFF) |=> (denied_o && !mem_req_o));    // R3
  AST_PASS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && en_i && mode_i == GM_PASS) |=> (rsp_grant_o && !mem_req_o)); // R4
  AST_CHECK_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && en_i && mode_i == GM_CHECK) |=> mem_req_o);                  // R5
endmodule

// File: rtl/apv_guard.sv
module apv_guard
  import apv_pkg::*;
#(
  parameter int NUM_MASTERS = 8,
  parameter int NUM_GROUPS  = 16,
  parameter int PG_W        = 3,
  parameter bit CFG_PGSZ    = 1'b1,
  localparam int MST_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic [PG_W-1:0]               pgsz_i,
  input  logic [NUM_MASTERS*WORD_W-1:0] mst_cfg_i,
  input  logic [NUM_GROUPS*WORD_W-1:0]  grp_cfg_i,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic [MST_W-1:0]              req_master_i,
  input  logic [WORD_W-1:0]             req_addr_i,
  output logic                          rsp_valid_o,
  output logic                          rsp_grant_o,
  output logic                          denied_o,
  output logic [WORD_W-1:0]             denied_addr_o,
  output logic                          mem_req_o,
  output logic [WORD_W-1:0]             mem_addr_o,
  input  logic                          mem_rvalid_i,
  input  logic [WORD_W-1:0]             mem_rdata_i
);
  grp_mode_e         mode;
  logic [WORD_W-1:0] base, word_addr;
  logic [4:0]        bit_sel;

  apv_group_sel #(.NUM_MASTERS(NUM_MASTERS), .NUM_GROUPS(NUM_GROUPS)) u_sel (
    .master_i (req_master_i),
    .mst_cfg_i(mst_cfg_i),
    .grp_cfg_i(grp_cfg_i),
    .mode_o   (mode),
    .base_o   (base)
  );

  apv_index #(.PG_W(PG_W), .CFG_PGSZ(CFG_PGSZ)) u_idx (
    .addr_i     (req_addr_i),
    .base_i     (base),
    .pgsz_i     (pgsz_i),
    .word_addr_o(word_addr),
    .bit_o      (bit_sel)
  );

  apv_ctrl u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .addr_i       (req_addr_i),
    .mode_i       (mode),
    .word_addr_i  (word_addr),
    .bit_i        (bit_sel),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_grant_o  (rsp_grant_o),
    .denied_o     (denied_o),
    .denied_addr_o(denied_addr_o)
  );

  AST_GRANT_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_grant_o || denied_o) |-> rsp_valid_o);                             // R10
endmodule

// File: tb/apv_guard_tb.sv
module apv_guard_tb;
  localparam int NM = 8;
  localparam int NG = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic [2:0] pgsz = '0;
  logic [NM*32-1:0] mst_cfg = '0;
  logic [NG*32-1:0] grp_cfg = '0;
  logic req_valid = 1'b0;
  logic [2:0] req_master = '0;
  logic [31:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_grant, denied, mem_req;
  logic [31:0] denied_addr, mem_addr;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] mem [64];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  apv_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pgsz_i(pgsz),
    .mst_cfg_i(mst_cfg), .grp_cfg_i(grp_cfg),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_master_i(req_master), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_grant_o(rsp_grant),
    .denied_o(denied), .denied_addr_o(denied_addr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  // vector memory: one-cycle read latency
  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= mem[mem_addr[7:2]];
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  // one access; returns observed response fields
  task automatic access(input int m, input logic [31:0] a,
                        output logic g, output logic den, output logic [31:0] daddr,
                        output int nreq, output logic [31:0] maddr, output int lat,
                        output logic rdy_busy, output logic rdy_after, output logic den_after);
    @(negedge clk);
    req_valid = 1'b1; req_master = 3'(m); req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; nreq = 0; maddr = 'x;
    while (!rsp_valid && lat < 40) begin
      if (mem_req) begin nreq++; maddr = mem_addr; end
      @(negedge clk);
      lat++;
    end
    g = rsp_grant; den = denied; daddr = denied_addr; rdy_busy = req_ready;
    @(negedge clk);
    rdy_after = req_ready; den_after = denied;
  endtask

  function automatic logic [31:0] exp_waddr(input logic [31:0] base, input logic [31:0] a, input int ps);
    logic [31:0] page = a >> (12 + ps);
    return base + (page / 32) * 4;
  endfunction

  function automatic logic exp_grant(input logic [31:0] base, input logic [31:0] a, input int ps);
    logic [31:0] page = a >> (12 + ps);
    logic [31:0] w = mem[exp_waddr(base, a, ps) / 4];
    return ~w[31 - (page % 32)];
  endfunction

  task automatic t_reset;
    chk("R1 ready", 32'(req_ready), 1);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 grant", 32'(rsp_grant), 0);
    chk("R1 denied", 32'(denied), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
  endtask

  task automatic t_direct(input string rq, input int m, input logic [31:0] a, input logic eg);
    logic g, den, rb, ra, da; logic [31:0] daddr, maddr; int nreq, lat;
    access(m, a, g, den, daddr, nreq, maddr, lat, rb, ra, da);
    chk({rq, " grant"}, 32'(g), 32'(eg));
    chk({rq, " no read"}, nreq, 0);
    chk({rq, " latency"}, lat, 1);
    chk({rq, " R10 denied"}, 32'(den), 32'(!eg));
    if (!eg) chk({rq, " R10 denied addr"}, daddr, a);
  endtask

  task automatic t_checked(input string rq, input int m, input logic [31:0] a,
                           input logic [31:0] base, input int ps, input logic eg);
    logic g, den, rb, ra, da; logic [31:0] daddr, maddr; int nreq, lat;
    pgsz = 3'(ps);
    access(m, a, g, den, daddr, nreq, maddr, lat, rb, ra, da);
    chk({rq, " R5 one read"}, nreq, 1);
    chk({rq, " R5 R6 word addr"}, maddr, exp_waddr(base, a, ps));
    chk({rq, " R7 model"}, 32'(exp_grant(base, a, ps)), 32'(eg));
    chk({rq, " R7 grant"}, 32'(g), 32'(eg));
    chk({rq, " R10 denied"}, 32'(den), 32'(!eg));
    chk({rq, " R10 daddr"}, daddr, eg ? 32'h0 : a);
    chk({rq, " R9 busy"}, 32'(rb), 0);
    chk({rq, " R9 ready after"}, 32'(ra), 1);
    chk({rq, " R10 pulse"}, 32'(da), 0);
    chk({rq, " latency"}, lat, 3);
  endtask

  task automatic t_back_to_back;
    // held-valid request: second is not accepted until the first completes
    int cyc = 0; int nrsp = 0;
    pgsz = 3'd0;
    @(negedge clk);
    req_valid = 1'b1; req_master = 3'd2; req_addr = 32'h0000_1000;
    while (nrsp < 2 && cyc < 40) begin
      @(negedge clk); cyc++;
      if (rsp_valid) nrsp++;
      if (rsp_valid && nrsp == 2) req_valid = 1'b0;
    end
    req_valid = 1'b0;
    @(negedge clk);
    // each lookup: 3 cycles to response plus one idle accept cycle
    chk("R9 back-to-back span", cyc, 7);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[16] = 32'h8000_0001;
    mem[17] = 32'h4000_0000;
    mem[20] = 32'h0000_0000;
    mem[32] = 32'h0400_0000;
    // masters -> groups (R8: upper bits are noise)
    mst_cfg[0*32 +: 32] = 32'hFFFF_FF02;
    mst_cfg[1*32 +: 32] = 32'h1234_5605;
    mst_cfg[2*32 +: 32] = 32'h0000_0007;
    mst_cfg[3*32 +: 32] = 32'h0000_0009;
    mst_cfg[4*32 +: 32] = 32'h0000_0004;
    mst_cfg[5*32 +: 32] = 32'hDEAD_BEE7;
    mst_cfg[6*32 +: 32] = 32'h0000_000B;
    grp_cfg[2*32 +: 32]  = 32'h0000_0100;
    grp_cfg[4*32 +: 32]  = 32'h0000_0102;
    grp_cfg[5*32 +: 32]  = 32'h0000_0103;
    grp_cfg[7*32 +: 32]  = 32'h0000_0041;
    grp_cfg[9*32 +: 32]  = 32'h0000_0081;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();

    t_direct("R3 inactive", 0, 32'h0000_3000, 1'b0);
    t_direct("R3 pass w/o active", 4, 32'h0000_5000, 1'b0);
    t_direct("R3 unconfigured", 6, 32'h0000_0000, 1'b0);
    t_direct("R4 passthrough", 1, 32'h0000_0000, 1'b1);
    t_direct("R8 upper bits ignored", 1, 32'hFFFF_F000, 1'b1);

    t_checked("R7 page0 bit31", 2, 32'h0000_0000, 32'h40, 0, 1'b0);
    t_checked("R7 page1 bit30", 2, 32'h0000_1000, 32'h40, 0, 1'b1);
    t_checked("R7 page31 bit0", 2, 32'h0001_F000, 32'h40, 0, 1'b0);
    t_checked("R5 page32 next word", 2, 32'h0002_0000, 32'h40, 0, 1'b1);
    t_checked("R5 page33", 2, 32'h0002_1FFC, 32'h40, 0, 1'b0);
    t_checked("R6 16K pages", 2, 32'h0008_4000, 32'h40, 2, 1'b0);
    t_checked("R6 4K same addr", 2, 32'h0008_4000, 32'h40, 0, 1'b1);
    t_checked("R8 master5 group7", 5, 32'h0000_0000, 32'h40, 0, 1'b0);
    t_checked("R5 group9 base", 3, 32'h0000_5000, 32'h80, 0, 1'b0);
    t_checked("R5 group9 grant", 3, 32'h0000_4000, 32'h80, 0, 1'b1);

    en = 1'b0;
    t_direct("R2 bypass checked grp", 2, 32'h0000_0000, 1'b1);
    t_direct("R2 bypass inactive grp", 0, 32'h0000_0000, 1'b1);
    en = 1'b1;

    t_back_to_back();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule